// File: doc/BRIEF.md
# Double-Rate Write Data Capture

This block takes write data from a source-synchronous bus whose strobe toggles once per core clock period. One data word is captured on the rising strobe edge and a second on the falling edge. Each rising/falling pair is joined into one double-width word, which is handed to a memory core as a single write in one clock cycle. A per-byte data-mask input is sampled on the same edges as the data. A masked byte turns into a cleared byte-enable bit on the core write, so that byte is not stored.

A write command on the core clock arms the block. It carries a start column and a burst-length code. The block then accepts exactly burst-length/2 strobe pairs and writes each one to the core with its own column address. It raises a one-cycle done pulse with the final write and then ignores further strobe edges until a new command arrives. The strobe is treated as an ideal clock whose rising edge comes a quarter period after the core clock edge.

Top module: `ddr_wr_capture`

## Requirements
- R1: For each accepted strobe pair, the word captured on the rising edge appears on `core_data[DW-1:0]` and the word captured on the falling edge appears on `core_data[2*DW-1:DW]`.
- R2: Every accepted strobe pair produces exactly one `core_wr` pulse, which is visible in the core clock cycle that follows the cycle in which the pair was driven. In every other cycle `core_wr` is low.
- R3: Bit i of `dm` masks byte i of the beat it is sampled with. `core_be` bit i is the inverse of the rising-edge mask bit i, and `core_be` bit MW+i is the inverse of the falling-edge mask bit i.
- R4: The burst-length code on `wr_cmd_bl` selects the number of beats: 0 gives 2, 1 gives 4, and 2 or 3 give 8. A burst performs beats/2 core writes.
- R5: Bit 0 of the start column is taken as 0. Each successive write of a burst advances the column by 2. The column wraps inside the aligned block of size equal to the beat count, and the bits above that block are unchanged.
- R6: `burst_done` is high for exactly one cycle, in the same cycle as the last core write of the burst.
- R7: Strobe pairs driven while no burst is active, including those that follow the last pair of a burst, produce no core write.
- R8: A write command that arrives while a burst is active is ignored. The running burst keeps its columns and its length.
- R9: While reset is applied, and after it is released, `core_wr` and `burst_done` stay low until a burst delivers data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_cmd | input | 1 | Write command strobe, one core clock cycle |
| wr_cmd_col | input | COL_W | Start column of the burst |
| wr_cmd_bl | input | 2 | Burst-length code |
| dqs | input | 1 | Data strobe, both edges sample data |
| dq | input | DW | Write data beat |
| dm | input | DW/8 | Per-byte mask for the current beat, high masks |
| core_wr | output | 1 | Core write enable |
| core_col | output | COL_W | Column of the core write |
| core_data | output | 2*DW | Assembled write word |
| core_be | output | DW/4 | Byte enables of the assembled word |
| burst_done | output | 1 | End-of-burst pulse |

## Verification
If the beat counter holds a wrong value, the block shows it at the ports in one of two ways. The done pulse arrives early or late, or a write appears for a pair that should have been dropped. Either way the error is visible in the cycle right after the affected pair. If the column base or the wrap mask is corrupted, the very next `core_col` is wrong. If the rising and falling captures are swapped or the mask is misrouted, the affected halves of `core_data` or `core_be` are wrong on the same write. The reference model predicts the outputs for every core cycle, so any write in the wrong cycle is caught in that cycle.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

  localparam int BL_MAX = 8;
  localparam int CNT_W  = $clog2(BL_MAX / 2);

  typedef logic [1:0] bl_code_t;

  // Beat count selected by a burst-length code.
  function automatic logic [3:0] bl_beats(input bl_code_t code);
    case (code)
      2'd0:    bl_beats = 4'd2;
      2'd1:    bl_beats = 4'd4;
      default: bl_beats = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/wcap_rst_sync.sv
module wcap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/wcap_beat_capture.sv
// Strobe-domain capture: rising beat into a holding register, falling beat
// completes the pair and flips a toggle that the core domain watches.
module wcap_beat_capture #(
  parameter int DW = 8,
  localparam int MW = DW / 8
) (
  input  logic            dqs,
  input  logic            rst_n,
  input  logic            armed,
  input  logic [DW-1:0]   dq,
  input  logic [MW-1:0]   dm,
  output logic [2*DW-1:0] pair_data,
  output logic [2*MW-1:0] pair_mask,
  output logic            pair_tog
);

  logic          rise_vld_q;
  logic [DW-1:0] lo_data_q;
  logic [MW-1:0] lo_mask_q;
  logic          rise_en;
  logic          fall_en;

  assign rise_en = armed;
  assign fall_en = rise_vld_q;

  always_ff @(posedge dqs or negedge rst_n) begin
    if (!rst_n) rise_vld_q <= 1'b0;
    else        rise_vld_q <= rise_en;
  end

  always_ff @(posedge dqs) begin
    if (rise_en) begin
      lo_data_q <= dq;
      lo_mask_q <= dm;
    end
  end

  always_ff @(negedge dqs or negedge rst_n) begin
    if (!rst_n)       pair_tog <= 1'b0;
    else if (fall_en) pair_tog <= ~pair_tog;
  end

  always_ff @(negedge dqs) begin
    if (fall_en) begin
      pair_data <= {dq, lo_data_q};
      pair_mask <= {dm, lo_mask_q};
    end
  end

endmodule

// File: rtl/wcap_burst_ctrl.sv
module wcap_burst_ctrl
  import wcap_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [COL_W-1:0] cmd_col,
  input  bl_code_t         cmd_bl,
  input  logic             pair_new,
  output logic             armed,
  output logic [COL_W-1:0] cur_col,
  output logic             done
);

  logic             armed_q, armed_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [3:0]       beats_q, beats_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d;
  logic [CNT_W-1:0] words_m1;
  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] step;
  logic             last;

  assign words_m1  = CNT_W'(beats_q[3:1] - 3'd1);
  assign wrap_mask = COL_W'(beats_q - 4'd1);
  assign step      = COL_W'({cnt_q, 1'b0});
  assign cur_col   = (base_q & ~wrap_mask) | ((base_q + step) & wrap_mask);
  assign last      = armed_q && pair_new && (cnt_q == words_m1);

  always_comb begin
    armed_d = armed_q;
    base_d  = base_q;
    beats_d = beats_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (!armed_q) begin
      if (cmd_vld) begin
        armed_d = 1'b1;
        base_d  = {cmd_col[COL_W-1:1], 1'b0};
        beats_d = bl_beats(cmd_bl);
        cnt_d   = '0;
      end
    end else if (pair_new) begin
      if (last) begin
        armed_d = 1'b0;
        cnt_d   = '0;
        done_d  = 1'b1;
      end else begin
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      base_q  <= '0;
      beats_q <= 4'd2;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      base_q  <= base_d;
      beats_q <= beats_d;
      cnt_q   <= cnt_d;
      done    <= done_d;
    end
  end

  assign armed = armed_q;

  // R8: a command during an active burst leaves the burst setup untouched
  a_r8_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cmd_vld) |=> (base_q == $past(base_q) && beats_q == $past(beats_q)));

  // R4: the write count never passes beats/2
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q <= words_m1));

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/wcap_word_assembler.sv
module wcap_word_assembler #(
  parameter int DW    = 8,
  parameter int COL_W = 10,
  localparam int MW   = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             pair_tog,
  input  logic [2*DW-1:0]  pair_data,
  input  logic [2*MW-1:0]  pair_mask,
  input  logic [COL_W-1:0] cur_col,
  output logic             pair_new,
  output logic             wr_en,
  output logic [COL_W-1:0] wr_col,
  output logic [2*DW-1:0]  wr_data,
  output logic [2*MW-1:0]  wr_be
);

  logic seen_q;
  logic load_en;

  assign pair_new = (pair_tog != seen_q);
  assign load_en  = pair_new && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      wr_en  <= 1'b0;
    end else begin
      if (pair_new) seen_q <= pair_tog;
      wr_en <= load_en;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      wr_col  <= cur_col;
      wr_data <= pair_data;
      wr_be   <= ~pair_mask;
    end
  end

endmodule

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture
  import wcap_pkg::*;
#(
  parameter int DW    = 8,
  parameter int COL_W = 10,
  localparam int MW   = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic [COL_W-1:0] wr_cmd_col,
  input  logic [1:0]       wr_cmd_bl,
  input  logic             dqs,
  input  logic [DW-1:0]    dq,
  input  logic [MW-1:0]    dm,
  output logic             core_wr,
  output logic [COL_W-1:0] core_col,
  output logic [2*DW-1:0]  core_data,
  output logic [2*MW-1:0]  core_be,
  output logic             burst_done
);

  logic             rst_s_n;
  logic             armed;
  logic             pair_tog;
  logic             pair_new;
  logic [2*DW-1:0]  pair_data;
  logic [2*MW-1:0]  pair_mask;
  logic [COL_W-1:0] cur_col;

  wcap_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  wcap_beat_capture #(.DW(DW)) u_cap (
    .dqs       (dqs),
    .rst_n     (rst_s_n),
    .armed     (armed),
    .dq        (dq),
    .dm        (dm),
    .pair_data (pair_data),
    .pair_mask (pair_mask),
    .pair_tog  (pair_tog)
  );

  wcap_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cmd_vld  (wr_cmd),
    .cmd_col  (wr_cmd_col),
    .cmd_bl   (bl_code_t'(wr_cmd_bl)),
    .pair_new (pair_new),
    .armed    (armed),
    .cur_col  (cur_col),
    .done     (burst_done)
  );

  wcap_word_assembler #(.DW(DW), .COL_W(COL_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .armed     (armed),
    .pair_tog  (pair_tog),
    .pair_data (pair_data),
    .pair_mask (pair_mask),
    .cur_col   (cur_col),
    .pair_new  (pair_new),
    .wr_en     (core_wr),
    .wr_col    (core_col),
    .wr_data   (core_data),
    .wr_be     (core_be)
  );

  // R6: the done pulse coincides with a core write
  a_r6_done_with_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    burst_done |-> core_wr);

  // R7: a core write needs a burst that was active one cycle earlier
  a_r7_write_needs_burst: assert property (@(posedge clk) disable iff (!rst_s_n)
    core_wr |-> $past(armed));

endmodule

// File: tb/ddr_wr_capture_bench.sv
`timescale 1ns/1ps
module ddr_wr_capture_bench;

  localparam int DW = 8;
  localparam int COL_W = 10;
  localparam int MW = DW / 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_cmd = 1'b0;
  logic [COL_W-1:0] wr_cmd_col = '0;
  logic [1:0]       wr_cmd_bl = '0;
  logic             dqs = 1'b0;
  logic [DW-1:0]    dq = '0;
  logic [MW-1:0]    dm = '0;
  logic             core_wr;
  logic [COL_W-1:0] core_col;
  logic [2*DW-1:0]  core_data;
  logic [2*MW-1:0]  core_be;
  logic             burst_done;

  ddr_wr_capture #(.DW(DW), .COL_W(COL_W)) u_ddr_wr_capture (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_cmd_col(wr_cmd_col),
    .wr_cmd_bl(wr_cmd_bl), .dqs(dqs), .dq(dq), .dm(dm), .core_wr(core_wr),
    .core_col(core_col), .core_data(core_data), .core_be(core_be),
    .burst_done(burst_done)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit checking = 0;
  bit finished = 0;
  string idle_req = "R9";

  // expected results keyed by core cycle number
  int e_col[int];
  int e_data[int];
  int e_be[int];
  int e_done[int];

  // behavioural model state
  bit m_armed = 0;
  int m_base = 0;
  int m_beats = 2;
  int m_cnt = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // compare every core cycle against the model, away from the clock edge
  always @(negedge clk) begin
    if (checking) begin
      if (e_data.exists(cyc)) begin
        check("R2", int'(core_wr), 1);
        check("R1", int'(core_data), e_data[cyc]);
        check("R3", int'(core_be), e_be[cyc]);
        check("R5", int'(core_col), e_col[cyc]);
        check("R6", int'(burst_done), e_done[cyc]);
      end else begin
        check(idle_req, int'(core_wr), 0);
        check("R6", int'(burst_done), 0);
      end
    end
    cyc++;
  end

  function automatic int beats_of(input int code);
    if (code == 0) return 2;
    if (code == 1) return 4;
    return 8;
  endfunction

  task automatic command(input int col, input int code);
    @(posedge clk);
    #1;
    wr_cmd = 1'b1;
    wr_cmd_col = COL_W'(col);
    wr_cmd_bl = 2'(code);
    if (!m_armed) begin
      m_armed = 1;
      m_base = col & ~1;
      m_beats = beats_of(code);
      m_cnt = 0;
    end
    @(posedge clk);
    #1;
    wr_cmd = 1'b0;
  endtask

  task automatic pair(input int lo, input int lo_m, input int hi, input int hi_m);
    int p;
    int blk;
    @(posedge clk);
    #1;
    p = cyc;
    dq = DW'(lo);
    dm = MW'(lo_m);
    #1 dqs = 1'b1;
    #2;
    dq = DW'(hi);
    dm = MW'(hi_m);
    #2 dqs = 1'b0;
    if (m_armed) begin
      blk = m_base - (m_base % m_beats);
      e_col[p + 1] = blk + ((m_base + 2 * m_cnt) % m_beats);
      e_data[p + 1] = (hi << DW) | lo;
      e_be[p + 1] = ((~hi_m & ((1 << MW) - 1)) << MW) | (~lo_m & ((1 << MW) - 1));
      m_cnt++;
      if (m_cnt == m_beats / 2) begin
        e_done[p + 1] = 1;
        m_armed = 0;
      end else begin
        e_done[p + 1] = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state
    #13;
    check("R9", int'(core_wr), 0);
    check("R9", int'(burst_done), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    checking = 1;
    idle(2);

    // R7: pairs with no burst active
    idle_req = "R7";
    pair(8'h11, 0, 8'h22, 0);
    pair(8'h33, 1, 8'h44, 0);
    idle(2);

    // R4, R5: code 2 gives 8 beats, wrap inside an 8-column block
    idle_req = "R2";
    command(10'h2A5, 2);
    pair(8'hA1, 0, 8'hB1, 0);
    pair(8'hA2, 1, 8'hB2, 0);
    pair(8'hA3, 0, 8'hB3, 1);
    pair(8'hA4, 1, 8'hB4, 1);
    idle(2);

    // R4: code 1 gives 4 beats; the extra pair must be dropped (R7)
    idle_req = "R7";
    command(10'h013, 1);
    pair(8'h5A, 0, 8'hA5, 1);
    pair(8'hC3, 0, 8'h3C, 0);
    pair(8'hFF, 0, 8'hEE, 0);
    idle(2);

    // R4: code 0 gives 2 beats, top of column space
    command(10'h3FF, 0);
    pair(8'h01, 1, 8'h80, 0);
    pair(8'h02, 0, 8'h40, 0);
    idle(2);

    // R8: a second command mid-burst does not restart or resize it
    idle_req = "R8";
    command(10'h104, 3);
    pair(8'h10, 0, 8'h20, 0);
    command(10'h01E, 0);
    pair(8'h30, 0, 8'h40, 1);
    pair(8'h50, 1, 8'h60, 0);
    pair(8'h70, 0, 8'h80, 0);
    idle(2);

    // random data over a mix of burst lengths
    idle_req = "R2";
    for (int b = 0; b < 12; b++) begin
      command(int'($urandom_range(0, 1023)), b % 4);
      for (int k = 0; k < beats_of(b % 4) / 2 + (b % 2); k++)
        pair(int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
             int'($urandom_range(0, 255)), int'($urandom_range(0, 1)));
      idle(1);
    end
    idle(4);

    // R9: reset mid-burst clears the state
    idle_req = "R9";
    command(10'h040, 2);
    pair(8'h99, 0, 8'h88, 0);
    idle(1);
    checking = 0;
    #1 rst_n = 1'b0;
    m_armed = 0;
    @(negedge clk);
    check("R9", int'(core_wr), 0);
    check("R9", int'(burst_done), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    checking = 1;
    idle_req = "R7";
    pair(8'h12, 0, 8'h34, 0);
    idle(3);
    finish_run();
  end

endmodule